// File: doc/BRIEF.md
# UART Register Front End with Interrupt Unit

This block is the register side of a 16550-style UART that is attached to a 32-bit APB slave port. Each register takes a full 32-bit word, so register index n sits at byte offset 4n. Only the low byte of each word carries data. The block holds several pieces of state:

- the line control byte, including the bank-select bit that swaps the data and interrupt-enable slots for the two divisor bytes;
- the interrupt enables;
- the FIFO control settings;
- a 16-entry receive FIFO and a 16-entry transmit FIFO.

The serial shifters sit outside the block. They reach it through a push port on the receive side and a pop port on the transmit side.

An APB phase tracker turns the bus handshake into exactly one read or write strobe per transfer. It has three states:

- **APB_IDLE** moves to **APB_SETUP** when a select arrives without enable.
- **APB_SETUP** moves to **APB_ACCESS** when enable is raised, and the strobe fires in that cycle. It stays in APB_SETUP while select is held without enable, and returns to APB_IDLE if select drops.
- **APB_ACCESS** moves to APB_SETUP on a back-to-back select, and otherwise returns to APB_IDLE.

A receive-timeout tracker has three states:

- **TO_EMPTY** holds while the receive FIFO is empty.
- **TO_COUNT** is entered once data is present, and again after any push or pop. It counts idle cycles.
- **TO_FIRED** is entered when the count reaches `TIMEOUT_CYC`. It is left when the FIFO empties (back to TO_EMPTY) or on new activity (back to TO_COUNT).

A single registered interrupt line is the OR of the enabled causes.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset, the line control byte, interrupt enables and divisor all read 0, the status byte reads 0x60, the identification byte reads 0x01, and `irq` is low.
- R2: Registers sit at byte offsets 0 (data/divisor low), 4 (enables/divisor high), 8 (identification on read, FIFO control on write), 12 (line control) and 20 (line status). A write to any other offset changes nothing, and a read from one returns 0.
- R3: While line control bit 7 is 1, offsets 0 and 4 read and write the divisor low and high bytes, `divisor` shows {high, low}, and writes to offset 0 do not enter the transmit FIFO.
- R4: While line control bit 7 is 0, a write to offset 0 pushes its low byte into the 16-entry transmit FIFO. `tx_char` shows the oldest byte, and `tx_pop` removes it. A write into a full transmit FIFO is dropped. Status bit 5 is set when the transmit FIFO is empty, and bit 6 is set when it is empty and `tx_shift_busy` is low.
- R5: While line control bit 7 is 0, a read from offset 0 returns the oldest received byte and removes it. On an empty FIFO the read returns 0. Status bit 0 is set while the receive FIFO holds data.
- R6: A push into a full receive FIFO is dropped and sets an overrun flag. The flag raises the line-status cause and clears when the status register is read.
- R7: Status bit 2 is the parity-error flag stored with the oldest receive entry. Status bits 1, 3, 4 and 7 read 0.
- R8: In a FIFO control write, bit 1 empties the receive FIFO, bit 2 empties the transmit FIFO, bit 0 sets the FIFO enable and bits 7:6 set the trigger code.
- R9: With the FIFO enable set, the receive cause is active when the receive count is at least the trigger level. The trigger codes 00, 01, 10 and 11 give levels of 1, 4, 8 and 14 entries.
- R10: With the FIFO enable clear, the receive cause is active whenever the receive FIFO holds data.
- R11: With the FIFO enable set, a non-empty receive FIFO that has seen no push or pop for `TIMEOUT_CYC` cycles raises the timeout cause. Reading the FIFO empty clears it.
- R12: Enable bit 1 raises the transmit-empty cause while the transmit FIFO is empty. Enable bit 0 gates the receive and timeout causes, and enable bit 2 gates the line-status cause.
- R13: `irq` is the OR of the enabled causes, registered, so it changes one cycle after the change in state that caused it.
- R14: Read from offset 8, the identification byte has bits 7:6 equal to 11 when the FIFO enable is set and 00 otherwise. Its low nibble is 0001 when no enabled cause is active. Otherwise it names the enabled cause of highest priority, in the order line status 0110, receive data 0100, timeout 1100, transmit empty 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data (low byte used) |
| prdata | output | 32 | APB read data (upper 24 bits zero) |
| pready | output | 1 | APB ready, always high |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error for the delivered character |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| tx_char | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO holds data |
| tx_shift_busy | input | 1 | Transmit shifter is still sending |
| divisor | output | 16 | Baud divisor {high, low} |
| line_ctrl | output | 7 | Line control bits 6:0 for the shifters |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are the hardest to reach from the ports. One is the overrun case, where the receive FIFO must be filled past sixteen entries. The other is the timeout case, where the FIFO must stay non-empty but idle for a long run of cycles below the trigger level. The stimulus reaches the first by pushing seventeen characters back to back with only the line-status cause enabled. It then reads the status register and drains the FIFO, which shows that the seventeenth character never arrived. It reaches the second by setting the trigger to fourteen and pushing a single character. It then waits on both sides of the timeout window and checks that `irq` is still low before the window ends and high after it. Priority is checked by stacking the line, receive and transmit causes together and removing them one at a time, reading the identification byte after each step.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    // word offsets in bytes; register index n at 4*n
    localparam int OFS_DATA = 0;
    localparam int OFS_IEN  = 4;
    localparam int OFS_IDF  = 8;
    localparam int OFS_LCTL = 12;
    localparam int OFS_LSTS = 20;

    // identification nibble codes
    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_LINE = 4'b0110;
    localparam logic [3:0] ID_RXD  = 4'b0100;
    localparam logic [3:0] ID_TMO  = 4'b1100;
    localparam logic [3:0] ID_THRE = 4'b0010;

    typedef enum logic [1:0] {
        APB_IDLE   = 2'd0,
        APB_SETUP  = 2'd1,
        APB_ACCESS = 2'd2
    } apb_state_t;

    typedef enum logic [1:0] {
        TO_EMPTY = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty,
    output logic                       dropped
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty && !clr;
    assign do_push = push && !clr && (!full || do_pop);
    assign dropped = push && !clr && full && !do_pop;
    assign count   = cnt;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R4 / R6: a push into a full FIFO without a pop leaves it at capacity
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));

    // R8: a clear strobe empties the FIFO on the next cycle
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/uart_apb_fsm.sv
module uart_apb_fsm
    import uart_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb
);

    apb_state_t state_q;
    apb_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= APB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            APB_IDLE: begin
                if (psel && !penable) state_d = APB_SETUP;
            end
            APB_SETUP: begin
                if (psel && penable) state_d = APB_ACCESS;
                else if (!psel)      state_d = APB_IDLE;
            end
            APB_ACCESS: begin
                if (psel && !penable) state_d = APB_SETUP;
                else                  state_d = APB_IDLE;
            end
            default: state_d = APB_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = (state_q == APB_SETUP) && psel && penable && pwrite;
        rd_stb = (state_q == APB_SETUP) && psel && penable && !pwrite;
    end

    // R2: one strobe per transfer, never on two consecutive cycles
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_regs_pkg::*;
#(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    input  logic nonempty,
    output logic fired
);

    localparam int TW = $clog2(LIMIT + 1);

    to_state_t       state_q;
    to_state_t       state_d;
    logic [TW-1:0]   cnt_q;
    logic [TW-1:0]   cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!nonempty) begin
            state_d = TO_EMPTY;
            cnt_d   = '0;
        end else if (activity) begin
            state_d = TO_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TO_EMPTY: begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
                TO_COUNT: begin
                    if (cnt_q == TW'(LIMIT - 1)) state_d = TO_FIRED;
                    else                         cnt_d   = cnt_q + 1'b1;
                end
                TO_FIRED: state_d = TO_FIRED;
                default:  state_d = TO_EMPTY;
            endcase
        end
    end

    always_comb begin
        fired = (state_q == TO_FIRED);
    end

    // R11: an empty FIFO always returns the tracker to its idle state
    a_r11_empty_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> (state_q == TO_EMPTY));

    // R11: the idle counter never passes the limit
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TO_COUNT) |-> (cnt_q < TW'(LIMIT)));

endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              rx_push,
    input  logic [7:0]        rx_char,
    input  logic              rx_par_err,
    input  logic              tx_pop,
    output logic [7:0]        tx_char,
    output logic              tx_avail,
    input  logic              tx_shift_busy,
    output logic [15:0]       divisor,
    output logic [6:0]        line_ctrl,
    output logic              irq
);

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    // bus phase
    logic wr_stb;
    logic rd_stb;

    // registers
    logic [7:0] lcr_q;
    logic [2:0] ier_q;
    logic [7:0] dll_q;
    logic [7:0] dlm_q;
    logic       fifo_en_q;
    logic [1:0] trig_q;
    logic       ovr_q;
    logic       irq_q;

    // decode
    logic hit_data, hit_ien, hit_idf, hit_lctl, hit_lsts;
    logic dlab;
    logic tx_push_stb, rx_pop_stb, lsr_rd, fcr_wr;
    logic rx_clr, tx_clr;

    // FIFO side
    logic [8:0]    rx_head;
    logic [CW-1:0] rx_count;
    logic [CW-1:0] tx_count;
    logic          rx_full, rx_empty, rx_drop;
    logic          tx_full, tx_empty, tx_drop;
    logic          rx_nonempty;
    logic          to_fired;

    // interrupt causes
    logic [CW-1:0] trig_lvl;
    logic          c_line, c_rxd, c_tmo, c_thre;
    logic [3:0]    iir_id;
    logic [7:0]    iir_byte;
    logic [7:0]    lsr_byte;
    logic [7:0]    rd_byte;

    logic unused_bits;
    assign unused_bits = ^{pwdata[31:8], rx_full, tx_full, tx_drop};

    uart_apb_fsm u_apb_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    assign dlab     = lcr_q[7];
    assign hit_data = (paddr == ADDR_W'(OFS_DATA));
    assign hit_ien  = (paddr == ADDR_W'(OFS_IEN));
    assign hit_idf  = (paddr == ADDR_W'(OFS_IDF));
    assign hit_lctl = (paddr == ADDR_W'(OFS_LCTL));
    assign hit_lsts = (paddr == ADDR_W'(OFS_LSTS));

    assign tx_push_stb = wr_stb && hit_data && !dlab;
    assign rx_pop_stb  = rd_stb && hit_data && !dlab;
    assign lsr_rd      = rd_stb && hit_lsts;
    assign fcr_wr      = wr_stb && hit_idf;
    assign rx_clr      = fcr_wr && pwdata[1];
    assign tx_clr      = fcr_wr && pwdata[2];

    uart_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .push    (rx_push),
        .din     ({rx_par_err, rx_char}),
        .pop     (rx_pop_stb),
        .dout    (rx_head),
        .count   (rx_count),
        .full    (rx_full),
        .empty   (rx_empty),
        .dropped (rx_drop)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .push    (tx_push_stb),
        .din     (pwdata[7:0]),
        .pop     (tx_pop),
        .dout    (tx_char),
        .count   (tx_count),
        .full    (tx_full),
        .empty   (tx_empty),
        .dropped (tx_drop)
    );

    assign rx_nonempty = !rx_empty;

    uart_rx_timeout #(.LIMIT(TIMEOUT_CYC)) u_rx_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (rx_push || rx_pop_stb),
        .nonempty (rx_nonempty),
        .fired    (to_fired)
    );

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q     <= '0;
            ier_q     <= '0;
            dll_q     <= '0;
            dlm_q     <= '0;
            fifo_en_q <= 1'b0;
            trig_q    <= '0;
        end else if (wr_stb) begin
            if (hit_data && dlab) dll_q <= pwdata[7:0];
            if (hit_ien) begin
                if (dlab) dlm_q <= pwdata[7:0];
                else      ier_q <= pwdata[2:0];
            end
            if (hit_idf) begin
                fifo_en_q <= pwdata[0];
                trig_q    <= pwdata[7:6];
            end
            if (hit_lctl) lcr_q <= pwdata[7:0];
        end
    end

    // overrun flag: set on a dropped push, cleared by a status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (rx_drop) ovr_q <= 1'b1;
        else if (lsr_rd)  ovr_q <= 1'b0;
    end

    // trigger level lookup
    always_comb begin
        unique case (trig_q)
            2'b00:   trig_lvl = CW'(1);
            2'b01:   trig_lvl = CW'(4);
            2'b10:   trig_lvl = CW'(8);
            default: trig_lvl = CW'(14);
        endcase
    end

    // interrupt causes, each gated by its enable
    always_comb begin
        c_line = ier_q[2] && (ovr_q || (rx_nonempty && rx_head[8]));
        c_rxd  = ier_q[0] && (fifo_en_q ? (rx_count >= trig_lvl) : rx_nonempty);
        c_tmo  = ier_q[0] && fifo_en_q && to_fired && rx_nonempty;
        c_thre = ier_q[1] && tx_empty;
    end

    always_comb begin
        if (c_line)      iir_id = ID_LINE;
        else if (c_rxd)  iir_id = ID_RXD;
        else if (c_tmo)  iir_id = ID_TMO;
        else if (c_thre) iir_id = ID_THRE;
        else             iir_id = ID_NONE;
        iir_byte = {fifo_en_q, fifo_en_q, 2'b00, iir_id};
        lsr_byte = {1'b0, tx_empty && !tx_shift_busy, tx_empty, 2'b00,
                    rx_nonempty && rx_head[8], 1'b0, rx_nonempty};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= c_line || c_rxd || c_tmo || c_thre;
    end

    // read mux
    always_comb begin
        rd_byte = 8'h00;
        if (hit_data)      rd_byte = dlab ? dll_q : (rx_nonempty ? rx_head[7:0] : 8'h00);
        else if (hit_ien)  rd_byte = dlab ? dlm_q : {5'b0, ier_q};
        else if (hit_idf)  rd_byte = iir_byte;
        else if (hit_lctl) rd_byte = lcr_q;
        else if (hit_lsts) rd_byte = lsr_byte;
    end

    assign prdata    = {24'h0, rd_byte};
    assign pready    = 1'b1;
    assign divisor   = {dlm_q, dll_q};
    assign line_ctrl = lcr_q[6:0];
    assign tx_avail  = !tx_empty;
    assign irq       = irq_q;

    // R3: with the divisor bank selected the transmit FIFO only shrinks or clears
    a_r3_no_push_in_div_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (dlab && !tx_pop && !tx_clr) |=> (tx_count == $past(tx_count)));

    // R6: a status read without a fresh drop clears the overrun flag
    a_r6_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_drop) |=> !ovr_q);

    // R6: a dropped push always leaves the overrun flag set
    a_r6_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> ovr_q);

    // R13: with every enable clear in the previous cycle, irq stays low
    a_r13_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ier_q) == 3'b000) |-> !irq_q);

    // R5: an empty receive read returns zero on the bus
    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_stb && rx_empty) |-> (prdata == 32'h0));

endmodule

// File: tb/test_uart_apb_regs.sv
`timescale 1ns/1ps
module test_uart_apb_regs;

    localparam int AW = 8;
    localparam int TO = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          rx_push = 1'b0;
    logic [7:0]    rx_char = '0;
    logic          rx_par_err = 1'b0;
    logic          tx_pop = 1'b0;
    logic [7:0]    tx_char;
    logic          tx_avail;
    logic          tx_shift_busy = 1'b0;
    logic [15:0]   divisor;
    logic [6:0]    line_ctrl;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    uart_apb_regs #(.ADDR_W(AW), .FIFO_DEPTH(16), .TIMEOUT_CYC(TO)) i_uart_apb_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .rx_push(rx_push), .rx_char(rx_char), .rx_par_err(rx_par_err),
        .tx_pop(tx_pop), .tx_char(tx_char), .tx_avail(tx_avail),
        .tx_shift_busy(tx_shift_busy), .divisor(divisor), .line_ctrl(line_ctrl),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = AW'(addr); pwdata = {24'hDEAD_00, data};
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // driver: queue the expected word, then run the read transfer
    task automatic apb_read(input int addr, input logic [7:0] exp, input string tag);
        exp_q.push_back({24'h0, exp});
        tag_q.push_back(tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = AW'(addr);
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // monitor: compares each completed read against the scoreboard queue
    always begin
        @(negedge clk);
        #1;
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underrun", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), prdata, exp_q.pop_front());
            end
        end
    end

    task automatic push_rx(input logic [7:0] c, input logic perr);
        @(negedge clk);
        rx_push = 1'b1; rx_char = c; rx_par_err = perr;
        @(negedge clk);
        rx_push = 1'b0; rx_par_err = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 divisor", divisor, 0);
        chk("R1 tx_avail", tx_avail, 0);
        apb_read(12, 8'h00, "R1 lcr");
        apb_read(4,  8'h00, "R1 ier");
        apb_read(8,  8'h01, "R1 iir");
        apb_read(20, 8'h60, "R1 lsr");

        // R3 divisor bank
        apb_write(12, 8'h83);
        apb_write(0, 8'h34);
        apb_write(4, 8'h12);
        chk("R3 divisor", divisor, 16'h1234);
        chk("R3 no tx push", tx_avail, 0);
        chk("R3 line_ctrl", line_ctrl, 7'h03);
        apb_read(0, 8'h34, "R3 dll read");
        apb_read(4, 8'h12, "R3 dlm read");
        apb_write(12, 8'h03);
        apb_read(4, 8'h00, "R3 ier unaffected");

        // R2 unmapped offsets
        apb_write(16, 8'hFF);
        apb_write(24, 8'hFF);
        apb_write(2, 8'hFF);
        apb_read(16, 8'h00, "R2 read 16");
        apb_read(24, 8'h00, "R2 read 24");
        apb_read(12, 8'h03, "R2 lcr kept");
        apb_read(4,  8'h00, "R2 ier kept");
        chk("R2 divisor kept", divisor, 16'h1234);
        chk("R2 no tx push", tx_avail, 0);

        // R4 transmit path and status bits 5/6
        apb_write(0, 8'hA5);
        apb_write(0, 8'h5A);
        chk("R4 tx_avail", tx_avail, 1);
        chk("R4 head", tx_char, 8'hA5);
        apb_read(20, 8'h00, "R4 lsr busy");
        pop_tx();
        chk("R4 second", tx_char, 8'h5A);
        pop_tx();
        chk("R4 drained", tx_avail, 0);
        tx_shift_busy = 1'b1;
        apb_read(20, 8'h20, "R4 lsr shifter busy");
        tx_shift_busy = 1'b0;
        apb_read(20, 8'h60, "R4 lsr all idle");
        for (int i = 0; i < 17; i++) apb_write(0, 8'h40 + 8'(i));
        for (int i = 0; i < 16; i++) begin
            chk("R4 full order", tx_char, 8'h40 + 8'(i));
            pop_tx();
        end
        chk("R4 17th dropped", tx_avail, 0);

        // R5 / R7 receive read and parity flag
        apb_read(0, 8'h00, "R5 empty read");
        push_rx(8'h11, 1'b0);
        push_rx(8'h22, 1'b1);
        apb_read(20, 8'h61, "R5 lsr data");
        apb_read(0, 8'h11, "R5 first");
        apb_read(20, 8'h65, "R7 parity head");
        apb_read(0, 8'h22, "R5 second");
        apb_read(20, 8'h60, "R5 lsr empty");

        // R6 overrun
        apb_write(4, 8'h04);
        for (int i = 0; i < 17; i++) push_rx(8'h80 + 8'(i), 1'b0);
        idle(2);
        chk("R6 irq on overrun", irq, 1);
        apb_read(8, 8'h06, "R6 iir line");
        apb_read(20, 8'h61, "R6 lsr");
        idle(2);
        chk("R6 flag cleared irq", irq, 0);
        apb_read(8, 8'h01, "R6 iir none");
        for (int i = 0; i < 16; i++) apb_read(0, 8'h80 + 8'(i), "R6 drain order");
        apb_read(20, 8'h60, "R6 17th dropped");

        // R8 / R9 trigger levels
        apb_write(4, 8'h01);
        apb_write(8, 8'h01);
        push_rx(8'h01, 1'b0);
        idle(2);
        chk("R9 level 1", irq, 1);
        apb_read(8, 8'hC4, "R9 iir rx");
        apb_write(8, 8'h43);
        apb_read(20, 8'h60, "R8 rx cleared");
        for (int i = 0; i < 3; i++) push_rx(8'(i), 1'b0);
        idle(2);
        chk("R9 below 4", irq, 0);
        push_rx(8'h03, 1'b0);
        idle(2);
        chk("R9 level 4", irq, 1);
        apb_write(8, 8'h83);
        for (int i = 0; i < 7; i++) push_rx(8'(i), 1'b0);
        idle(2);
        chk("R9 below 8", irq, 0);
        push_rx(8'h07, 1'b0);
        idle(2);
        chk("R9 level 8", irq, 1);
        apb_write(8, 8'hC3);
        for (int i = 0; i < 13; i++) push_rx(8'(i), 1'b0);
        idle(2);
        chk("R9 below 14", irq, 0);
        push_rx(8'h0D, 1'b0);
        idle(2);
        chk("R9 level 14", irq, 1);
        apb_write(8, 8'hC3);

        // R8 transmit clear
        apb_write(0, 8'h99);
        chk("R8 tx loaded", tx_avail, 1);
        apb_write(8, 8'hC5);
        chk("R8 tx cleared", tx_avail, 0);

        // R11 character timeout
        push_rx(8'h77, 1'b0);
        idle(30);
        chk("R11 before window", irq, 0);
        idle(50);
        chk("R11 after window", irq, 1);
        apb_read(8, 8'hCC, "R11 iir timeout");
        apb_read(0, 8'h77, "R11 pop");
        idle(2);
        chk("R11 cleared", irq, 0);

        // R10 FIFO disabled
        apb_write(8, 8'h02);
        push_rx(8'h55, 1'b0);
        idle(2);
        chk("R10 any data", irq, 1);
        apb_read(8, 8'h04, "R10 iir");
        apb_read(0, 8'h55, "R10 pop");

        // R12 / R13 transmit empty and latency
        apb_write(4, 8'h00);
        idle(2);
        chk("R13 masked", irq, 0);
        apb_write(4, 8'h02);
        chk("R13 one cycle later", irq, 0);
        idle(1);
        chk("R12 thre irq", irq, 1);
        apb_read(8, 8'h02, "R12 iir thre");
        apb_write(0, 8'h10);
        idle(2);
        chk("R12 tx not empty", irq, 0);
        pop_tx();

        // R14 priority
        apb_write(4, 8'h07);
        apb_write(8, 8'h07);
        for (int i = 0; i < 17; i++) push_rx(8'(i), 1'b0);
        apb_read(8, 8'hC6, "R14 line first");
        apb_read(20, 8'h61, "R14 lsr");
        apb_read(8, 8'hC4, "R14 rx second");
        apb_write(8, 8'h03);
        apb_read(8, 8'hC2, "R14 thre last");
        apb_write(4, 8'h00);
        apb_read(8, 8'hC1, "R14 none");

        idle(4);
        chk("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule